// File: doc/BRIEF.md
# Subtract-and-Flag Comparison Unit

This block compares two operands by forming their difference, A minus B, in a ripple subtractor and then reading the relation between them from the subtractor's status bits. It produces four raw status bits: zero, negative, borrow and overflow. It also decodes these bits into equality and into less-than and greater-than results. Each ordering result comes in an unsigned form and a two's-complement signed form. The block is purely combinational. It has no clock and holds no state, so its outputs follow the operands within the same cycle.

The unsigned ordering comes from the borrow. The signed ordering comes from negative combined with overflow. One subtractor therefore serves both interpretations of the same bit patterns. A datapath can place this unit next to an existing adder, or use it alone wherever both orderings of two words are needed.

Top module: `subcmp_flags`

## Requirements
- R1: `flag_z` is 1 exactly when every bit of the WIDTH-bit difference (A − B) mod 2^WIDTH is 0, which happens only when `op_a` equals `op_b`.
- R2: `flag_n` equals bit WIDTH−1, the most significant bit, of (A − B) mod 2^WIDTH.
- R3: `flag_c` is a borrow. It is 1 exactly when `op_a` is less than `op_b` as unsigned numbers, which is the inverse of the carry out of A + ~B + 1.
- R4: `flag_v` is 1 exactly when the sign bits of `op_a` and `op_b` differ and bit WIDTH−1 of the difference differs from the sign bit of `op_a`.
- R5: `rel_eq` equals `flag_z`.
- R6: `rel_ltu` is 1 exactly when `op_a` < `op_b` as unsigned numbers.
- R7: `rel_lts` is 1 exactly when `op_a` < `op_b` as two's-complement numbers, and it equals `flag_n` XOR `flag_v`.
- R8: `rel_gtu` is 1 exactly when `op_a` > `op_b` as unsigned numbers. This is the same as being neither unsigned-less nor equal.
- R9: `rel_gts` is 1 exactly when `op_a` > `op_b` as two's-complement numbers. This is the same as being neither signed-less nor equal.
- R10: For any pair of operands, exactly one of {`rel_eq`, `rel_ltu`, `rel_gtu`} is 1, and exactly one of {`rel_eq`, `rel_lts`, `rel_gts`} is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | Minuend operand A |
| op_b | input | WIDTH | Subtrahend operand B |
| flag_z | output | 1 | Difference is all zeros |
| flag_n | output | 1 | Top bit of the difference |
| flag_c | output | 1 | Borrow out of A − B |
| flag_v | output | 1 | Signed overflow of A − B |
| rel_eq | output | 1 | A equals B |
| rel_ltu | output | 1 | A below B, unsigned |
| rel_lts | output | 1 | A below B, signed |
| rel_gtu | output | 1 | A above B, unsigned |
| rel_gts | output | 1 | A above B, signed |

## Verification
The checker tests five relations whenever the operands change: equality against a direct operand compare, the borrow against an unsigned compare, the overflow rule against the operand signs and the negative bit, the signed less-than against a signed compare, and the one-hot condition on both triples of relation outputs. The exact value of the negative bit, and the cases that matter most, can only be shown by the bench's directed scenarios. These cases are the most negative value against zero and against the most positive value, equal operands, and runs of random pairs checked against integer arithmetic.

// File: rtl/subcmp_pkg.sv
// Package: shared types for the subtract-and-flag comparison unit.
// Assumes nothing beyond a positive operand width at the user.
package subcmp_pkg;

    // Raw status bits produced by the subtraction.
    typedef struct packed {
        logic z;   // difference is zero
        logic n;   // top bit of difference
        logic c;   // borrow (A below B unsigned)
        logic v;   // signed overflow
    } raw_flags_t;

    // Decoded relations for both interpretations.
    typedef struct packed {
        logic eq;
        logic ltu;
        logic lts;
        logic gtu;
        logic gts;
    } relation_t;

endpackage

// File: rtl/subcmp_ripple.sv
// Module: ripple subtractor computing A + ~B + 1.
// Assumes WIDTH >= 1; carry_out is the true carry (1 means no borrow).
module subcmp_ripple #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] diff_out,
    output logic             carry_out
);

    logic [WIDTH:0]   carry_chain;
    logic [WIDTH-1:0] b_inv;

    // Purpose: invert subtrahend and inject the +1 at the chain bottom.
    always_comb begin
        b_inv          = ~b_in;
        carry_chain[0] = 1'b1;
    end

    // One full-adder cell per bit position.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        // Purpose: sum and carry of one bit slice.
        always_comb begin
            diff_out[gi]      = a_in[gi] ^ b_inv[gi] ^ carry_chain[gi];
            carry_chain[gi+1] = (a_in[gi] & b_inv[gi])
                              | (carry_chain[gi] & (a_in[gi] ^ b_inv[gi]));
        end
    end

    // Purpose: expose the final carry.
    always_comb carry_out = carry_chain[WIDTH];

endmodule

// File: rtl/subcmp_flaggen.sv
// Module: derives raw Z, N, C, V bits from the subtractor result.
// Assumes carry_in is the true carry of A + ~B + 1; C is reported as borrow.
module subcmp_flaggen
    import subcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] diff_in,
    input  logic             carry_in,
    output raw_flags_t       flags_out
);

    localparam int MSB = WIDTH - 1;

    // Purpose: form each status bit from the difference and operand signs.
    always_comb begin
        flags_out.z = (diff_in == '0);
        flags_out.n = diff_in[MSB];
        flags_out.c = ~carry_in;
        flags_out.v = (a_in[MSB] ^ b_in[MSB]) & (diff_in[MSB] ^ a_in[MSB]);
    end

endmodule

// File: rtl/subcmp_decode.sv
// Module: decodes raw status bits into unsigned and signed relations.
// Assumes the flags come from A − B with C as borrow.
module subcmp_decode
    import subcmp_pkg::*;
(
    input  raw_flags_t flags_in,
    output relation_t  rel_out
);

    logic signed_below;

    // Purpose: signed ordering is negative corrected by overflow.
    always_comb signed_below = flags_in.n ^ flags_in.v;

    // Purpose: build equal, less and greater for both interpretations.
    always_comb begin
        rel_out.eq  = flags_in.z;
        rel_out.ltu = flags_in.c;
        rel_out.lts = signed_below;
        rel_out.gtu = ~flags_in.c & ~flags_in.z;
        rel_out.gts = ~signed_below & ~flags_in.z;
    end

endmodule

// File: rtl/subcmp_flags.sv
// Module: top of the subtract-and-flag comparison unit.
// Assumes operands are stable for the cycle they are used; purely combinational.
module subcmp_flags
    import subcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_c,
    output logic             flag_v,
    output logic             rel_eq,
    output logic             rel_ltu,
    output logic             rel_lts,
    output logic             rel_gtu,
    output logic             rel_gts
);

    logic [WIDTH-1:0] diff_w;
    logic             carry_w;
    raw_flags_t       flags_w;
    relation_t        rel_w;

    subcmp_ripple #(.WIDTH(WIDTH)) u_sub (
        .a_in      (op_a),
        .b_in      (op_b),
        .diff_out  (diff_w),
        .carry_out (carry_w)
    );

    subcmp_flaggen #(.WIDTH(WIDTH)) u_flags (
        .a_in      (op_a),
        .b_in      (op_b),
        .diff_in   (diff_w),
        .carry_in  (carry_w),
        .flags_out (flags_w)
    );

    subcmp_decode u_dec (
        .flags_in (flags_w),
        .rel_out  (rel_w)
    );

    // Purpose: drive the output ports from the internal structs.
    always_comb begin
        flag_z  = flags_w.z;
        flag_n  = flags_w.n;
        flag_c  = flags_w.c;
        flag_v  = flags_w.v;
        rel_eq  = rel_w.eq;
        rel_ltu = rel_w.ltu;
        rel_lts = rel_w.lts;
        rel_gtu = rel_w.gtu;
        rel_gts = rel_w.gts;
    end

endmodule

// File: rtl/subcmp_flags_chk.sv
// Module: checker bound to subcmp_flags; compares outputs with direct operand relations.
// Assumes a combinational top, so immediate assertions are evaluated on every change.
module subcmp_flags_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             flag_z,
    input logic             flag_n,
    input logic             flag_c,
    input logic             flag_v,
    input logic             rel_eq,
    input logic             rel_ltu,
    input logic             rel_lts,
    input logic             rel_gtu,
    input logic             rel_gts
);

    localparam int MSB = WIDTH - 1;

    // Purpose: check output relations against direct comparisons.
    always_comb begin
        p_zero_eq_r1: assert (flag_z == (op_a == op_b))
            else $error("zero flag disagrees with operand equality");
        p_borrow_r3: assert (flag_c == (op_a < op_b))
            else $error("borrow disagrees with unsigned compare");
        p_overflow_r4: assert (flag_v == ((op_a[MSB] != op_b[MSB]) && (flag_n != op_a[MSB])))
            else $error("overflow rule violated");
        p_signed_lt_r7: assert (rel_lts == ($signed(op_a) < $signed(op_b)))
            else $error("signed less-than wrong");
        p_onehot_u_r10: assert ($onehot({rel_eq, rel_ltu, rel_gtu}))
            else $error("unsigned relation not one-hot");
        p_onehot_s_r10: assert ($onehot({rel_eq, rel_lts, rel_gts}))
            else $error("signed relation not one-hot");
    end

endmodule

bind subcmp_flags subcmp_flags_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .flag_z  (flag_z),
    .flag_n  (flag_n),
    .flag_c  (flag_c),
    .flag_v  (flag_v),
    .rel_eq  (rel_eq),
    .rel_ltu (rel_ltu),
    .rel_lts (rel_lts),
    .rel_gtu (rel_gtu),
    .rel_gts (rel_gts)
);

// File: tb/sim_subcmp_flags.sv
// Bench: directed scenarios for subcmp_flags, each task checks its own results.
module sim_subcmp_flags;

    localparam int W = 8;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ALL_ONE = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic z, n, c, v, eq, ltu, lts, gtu, gts;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    subcmp_flags #(.WIDTH(W)) u0 (
        .op_a(a), .op_b(b),
        .flag_z(z), .flag_n(n), .flag_c(c), .flag_v(v),
        .rel_eq(eq), .rel_ltu(ltu), .rel_lts(lts), .rel_gtu(gtu), .rel_gts(gts)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s a=%0h b=%0h got=%0b exp=%0b", req, a, b, got, exp);
        end
    endtask

    // Drive a pair, wait one clock, compare every output with integer arithmetic.
    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv);
        int sa, sb, sd, ua, ub;
        logic [W-1:0] d;
        logic ev;
        @(negedge clk);
        a = av;
        b = bv;
        @(posedge clk);
        #1;
        ua = int'(av);
        ub = int'(bv);
        sa = int'($signed(av));
        sb = int'($signed(bv));
        sd = sa - sb;
        d  = av - bv;
        ev = (sd > int'($signed(MAX_POS))) || (sd < int'($signed(MIN_NEG)));
        chk("R1 zero",        z,   d == '0);
        chk("R2 negative",    n,   d[W-1]);
        chk("R3 borrow",      c,   ua < ub);
        chk("R4 overflow",    v,   ev);
        chk("R5 equal",       eq,  ua == ub);
        chk("R6 ltu",         ltu, ua < ub);
        chk("R7 lts",         lts, sa < sb);
        chk("R7 lts_nv",      lts, n ^ v);
        chk("R8 gtu",         gtu, ua > ub);
        chk("R9 gts",         gts, sa > sb);
        chk("R10 onehot_u",   1'b1, (32'(eq) + 32'(ltu) + 32'(gtu)) == 1);
        chk("R10 onehot_s",   1'b1, (32'(eq) + 32'(lts) + 32'(gts)) == 1);
    endtask

    task automatic t_reset_state;
        apply('0, '0);  // R1 R5: zero operands are equal
    endtask

    task automatic t_extremes;
        apply(MIN_NEG, '0);       // R7: most negative below zero, R8 above unsigned
        apply('0, MIN_NEG);       // R4: 0 - MIN overflows
        apply(MIN_NEG, MAX_POS);  // R4 overflow, R9 signed
        apply(MAX_POS, MIN_NEG);
        apply(MIN_NEG, MIN_NEG);
        apply(ALL_ONE, '0);       // R6 R7 split: -1 vs 0
        apply('0, ALL_ONE);
        apply(8'h06, 8'h05);
        apply(8'h05, 8'h06);
    endtask

    task automatic t_equal_sweep;
        for (int i = 0; i < 256; i += 17) apply(W'(i), W'(i));  // R1 R5
    endtask

    task automatic t_random;
        for (int i = 0; i < 600; i++) apply(W'($urandom), W'($urandom));
    endtask

    task automatic t_near;
        for (int i = 0; i < 100; i++) begin
            logic [W-1:0] r;
            r = W'($urandom);
            apply(r, r + 1'b1);  // R3 R6 adjacent values, wrap at top
            apply(r + 1'b1, r);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_extremes();
        t_equal_sweep();
        t_near();
        t_random();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule